// File: doc/BRIEF.md
# Clock-Crossing Control Register Writer

This block is an APB subordinate that owns a single control register whose flops sit in a separate destination clock domain. When an APB write hits the register, the block copies the write data into a holding register in the bus clock domain. It then raises a level request that a two-stage synchronizer carries into the destination domain. The destination side loads the held value into its register and answers with an acknowledge, which a second two-stage synchronizer brings back to the bus clock. The bus transfer is kept stalled with PREADY low until that returned acknowledge is seen. A completed transfer therefore always means the value is already in the destination register.

The request is lowered once the acknowledge arrives. No new crossing starts until the acknowledge has also fallen. A shadow copy of the last completed write is kept in the bus clock domain, and reads return it with no wait states. Each domain has its own synchronous, active-high reset.

Top module: `cdcw_reg_writer`

## Requirements
- R1: While both resets are held and just after they are released, pready is 0, prdata is 0, dst_reg is 0 and pslverr is 0.
- R2: A write to address REG_ADDR (default 8'h10) keeps pready low for at least two access cycles. pready rises only after the destination domain has loaded the value.
- R3: On the completion cycle of a write to REG_ADDR (psel, penable, pwrite and pready all 1), dst_reg already equals the pwdata of that transfer.
- R4: pready is high for exactly one cycle per transfer and is 0 in the cycle after completion.
- R5: A read of REG_ADDR completes on its first access cycle and returns the data of the most recent completed write to REG_ADDR.
- R6: A write to any other address completes on its first access cycle and changes neither dst_reg nor the read-back value. A read of any other address returns 0 with no wait.
- R7: pslverr is 0 on every cycle.
- R8: Successive writes to REG_ADDR all land in order. A new request is launched only after the previous acknowledge has fallen, and dst_reg ends with the last value written.
- R9: While the request is high and no acknowledge has returned, the request stays high and the held write data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst | input | 1 | Bus-domain synchronous reset, active high |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Transfer address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data (registered) |
| pready | output | 1 | Transfer complete (registered) |
| pslverr | output | 1 | Error response, always 0 |
| dclk | input | 1 | Destination clock |
| drst | input | 1 | Destination-domain synchronous reset, active high |
| dst_reg | output | DATA_W | Control register in the destination domain |

## Verification
Reads and writes to other addresses are due on the first access cycle, because pready is registered at the setup edge. A write to the register is due only after the request has passed two destination flops and the capture flop, the acknowledge has passed two bus flops, and pready has been registered. That is at least two waits, and more when the destination clock is slower. The bench therefore does not assume a fixed latency. It polls pready once per cycle in the middle of the low clock phase, counts the waits, and bounds them. It samples prdata and dst_reg in the same completion cycle, and samples pready again one cycle later.

// File: rtl/cdcw_pkg.sv
package cdcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_WAIT_LOW = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/cdcw_sync.sv
module cdcw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdcw_dst_side.sv
module cdcw_dst_side #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              dclk,
  input  logic              drst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] hold_async,
  output logic              ack,
  output logic [DATA_W-1:0] reg_q
);
  logic req_s;

  cdcw_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(dclk), .rst(drst), .d(req_async), .q(req_s)
  );

  always_ff @(posedge dclk) begin
    if (drst) begin
      ack   <= 1'b0;
      reg_q <= '0;
    end else begin
      ack <= req_s;
      if (req_s && !ack) reg_q <= hold_async;
    end
  end

  // The register is loaded once per request: it is frozen while the acknowledge is up.
  AST_CAPTURE_ONCE: assert property (@(posedge dclk) disable iff (drst)
    (ack && req_s) |=> $stable(reg_q)); // R8
endmodule

// File: rtl/cdcw_apb_side.sv
module cdcw_apb_side
  import cdcw_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          STAGES   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ack_async,
  output logic              req,
  output logic [DATA_W-1:0] hold
);
  xfer_state_t       state;
  logic              ack_s;
  logic [DATA_W-1:0] shadow;
  logic              hit;
  logic              setup_ph;
  logic              access_ph;

  cdcw_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(pclk), .rst(prst), .d(ack_async), .q(ack_s)
  );

  assign hit       = (paddr == REG_ADDR);
  assign setup_ph  = psel && !penable;
  assign access_ph = psel && penable;
  assign pslverr   = 1'b0;

  always_ff @(posedge pclk) begin
    if (prst) begin
      state  <= ST_IDLE;
      req    <= 1'b0;
      hold   <= '0;
      shadow <= '0;
      pready <= 1'b0;
      prdata <= '0;
    end else begin
      pready <= 1'b0;
      // zero-wait paths answered at the setup edge
      if (setup_ph && (!pwrite || !hit)) begin
        pready <= 1'b1;
        prdata <= (!pwrite && hit) ? shadow : '0;
      end
      case (state)
        ST_IDLE: begin
          if (access_ph && pwrite && hit && !pready) begin
            hold  <= pwdata;
            req   <= 1'b1;
            state <= ST_WAIT_ACK;
          end
        end
        ST_WAIT_ACK: begin
          if (ack_s) begin
            req    <= 1'b0;
            shadow <= hold;
            pready <= access_ph;
            state  <= ST_WAIT_LOW;
          end
        end
        ST_WAIT_LOW: begin
          if (!ack_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge pclk) disable iff (prst)
    pready |=> !pready); // R4
  AST_REQ_AFTER_ACK_LOW: assert property (@(posedge pclk) disable iff (prst)
    $rose(req) |-> !ack_s); // R8
  AST_REQ_HELD: assert property (@(posedge pclk) disable iff (prst)
    (req && !ack_s) |=> (req && $stable(hold))); // R9
  AST_NO_ERROR: assert property (@(posedge pclk) disable iff (prst)
    !pslverr); // R7
  AST_WDATA_HELD: assert property (@(posedge pclk) disable iff (prst)
    (access_ph && pwrite && !pready) |=> ($stable(pwdata) && $stable(paddr))); // R2
endmodule

// File: rtl/cdcw_reg_writer.sv
module cdcw_reg_writer #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          STAGES   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic              pclk,
  input  logic              prst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              dclk,
  input  logic              drst,
  output logic [DATA_W-1:0] dst_reg
);
  logic              req;
  logic              ack;
  logic [DATA_W-1:0] hold;

  cdcw_apb_side #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES), .REG_ADDR(REG_ADDR)
  ) u_apb (
    .pclk(pclk), .prst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ack_async(ack), .req(req), .hold(hold)
  );

  cdcw_dst_side #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dst (
    .dclk(dclk), .drst(drst), .req_async(req), .hold_async(hold),
    .ack(ack), .reg_q(dst_reg)
  );

  // Completion of a register write implies the destination already holds the value.
  AST_DONE_IMPLIES_LANDED: assert property (@(posedge pclk) disable iff (prst || drst)
    (psel && penable && pwrite && pready && paddr == REG_ADDR) |-> (dst_reg == pwdata)); // R3
endmodule

// File: tb/cdcw_reg_writer_tb.sv
module cdcw_reg_writer_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] RA = 8'h10;
  localparam int NV = 9;
  localparam int VW = 1 + AW + DW + DW;
  // {is_write, addr, data, expected dst_reg after write / expected prdata for read}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 8'h10, 32'hA5A5_0001, 32'hA5A5_0001},
    {1'b0, 8'h10, 32'h0,         32'hA5A5_0001},
    {1'b1, 8'h24, 32'hDEAD_BEEF, 32'hA5A5_0001},
    {1'b0, 8'h24, 32'h0,         32'h0},
    {1'b0, 8'h10, 32'h0,         32'hA5A5_0001},
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 8'h10, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 8'h10, 32'h1234_5678, 32'h1234_5678},
    {1'b0, 8'h10, 32'h0,         32'h1234_5678}
  };

  logic pclk = 1'b0, dclk = 1'b0;
  logic prst = 1'b1, drst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata, dst_reg;
  logic pready, pslverr;
  int n_chk = 0, n_bad = 0;

  always #5 pclk = ~pclk;
  always #8.5 dclk = ~dclk;

  cdcw_reg_writer #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) u_dut (
    .pclk(pclk), .prst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .dclk(dclk), .drst(drst), .dst_reg(dst_reg)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int waits, output logic [DW-1:0] rd, output logic [DW-1:0] dq,
                      output logic err, output logic after);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1; waits = 0;
    #1;
    while (!pready && waits < 200) begin
      @(negedge pclk); #1; waits++;
    end
    rd = prdata; dq = dst_reg; err = pslverr;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwdata = '0;
    #1;
    after = pready;
  endtask

  initial begin
    int w;
    logic [DW-1:0] rd, dq;
    logic err, aft;
    repeat (4) @(negedge pclk);
    chk(pready == 1'b0 && prdata == '0, "R1", {31'b0, pready}, 32'h0);
    chk(dst_reg == '0, "R1", dst_reg, 32'h0);
    prst = 1'b0; drst = 1'b0;
    repeat (3) @(negedge pclk);
    chk(pready == 1'b0 && pslverr == 1'b0, "R1", {31'b0, pready}, 32'h0);
    chk(dst_reg == '0, "R1", dst_reg, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic wr_v; logic [AW-1:0] a_v; logic [DW-1:0] d_v, e_v;
      {wr_v, a_v, d_v, e_v} = VEC[i];
      xfer(wr_v, a_v, d_v, w, rd, dq, err, aft);
      chk(w < 200, "R2 watchdog", w, 200);
      chk(err == 1'b0, "R7", {31'b0, err}, 32'h0);
      chk(aft == 1'b0, "R4", {31'b0, aft}, 32'h0);
      if (wr_v && a_v == RA) begin
        chk(w >= 2, "R2", w, 2);
        chk(dq == e_v, "R3", dq, e_v);
      end else if (wr_v) begin
        chk(w == 0, "R6", w, 0);
        chk(dq == e_v, "R6", dq, e_v);
      end else begin
        chk(w == 0, a_v == RA ? "R5" : "R6", w, 0);
        chk(rd == e_v, a_v == RA ? "R5" : "R6", rd, e_v);
      end
    end

    // R8: a run of register writes, final value must be the last one
    xfer(1'b1, RA, 32'h0000_00AA, w, rd, dq, err, aft);
    xfer(1'b1, RA, 32'h0000_00BB, w, rd, dq, err, aft);
    chk(dq == 32'h0000_00BB, "R8", dq, 32'h0000_00BB);
    xfer(1'b1, RA, 32'h0000_00CC, w, rd, dq, err, aft);
    chk(dq == 32'h0000_00CC && w >= 2, "R8", dq, 32'h0000_00CC);
    repeat (20) @(negedge pclk);
    chk(dst_reg == 32'h0000_00CC, "R8", dst_reg, 32'h0000_00CC);
    xfer(1'b0, RA, '0, w, rd, dq, err, aft);
    chk(rd == 32'h0000_00CC, "R5", rd, 32'h0000_00CC);

    // R1: reset again, register and read-back return to zero
    prst = 1'b1; drst = 1'b1;
    repeat (4) @(negedge pclk);
    chk(dst_reg == '0 && pready == 1'b0, "R1", dst_reg, 32'h0);
    prst = 1'b0; drst = 1'b0;
    xfer(1'b0, RA, '0, w, rd, dq, err, aft);
    chk(rd == '0, "R1", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule